// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block picks where each of the two ALU operands of the execute stage comes from in a five-stage in-order pipeline. It compares the two source register ids of the instruction now in execute with the destination ids of the two older instructions still in flight: one in the memory stage and one in the write-back stage. When an older instruction will write a register that the current one reads, the pending result is routed to the ALU instead of the stale register-file value. Read-after-write hazards between neighbouring instructions are therefore resolved without a stall.

Selection is combinational. For each operand the unit produces a 2-bit select code and drives an operand multiplexer with it. A registered copy of each muxed operand is provided, so that the chosen value can be seen one clock later. Register 0 always reads as zero, so a write to it is never forwarded. When both older stages target the same register, the memory-stage result is taken because it is the more recent write.

Top module: `fwd_unit`

## Requirements
- R1: `fwd_a_o` is 2'b10 whenever `mem_we_i` is 1, `mem_rd_i` is nonzero and `mem_rd_i` equals `src_a_id_i`.
- R2: `fwd_a_o` is 2'b01 whenever `wb_we_i` is 1, `wb_rd_i` is nonzero, `wb_rd_i` equals `src_a_id_i` and the R1 condition does not hold.
- R3: In all other cases `fwd_a_o` is 2'b00, meaning the register-file value is used. The code 2'b11 never appears on either select.
- R4: `fwd_b_o` follows the rules of R1 to R3 using `src_b_id_i`, independently of operand A.
- R5: A source id of 0 always gives select 2'b00, even when a stage has its write enable set and its destination id is 0.
- R6: When the memory stage and the write-back stage both match a source id, the select is 2'b10.
- R7: A stage whose write enable is 0 is never forwarded, even when its destination id matches.
- R8: On each rising clock edge, `opnd_a_o` and `opnd_b_o` load the muxed operand. Select 00 gives the register-file data of that operand, 01 gives `wb_data_i` and 10 gives `mem_data_i`.
- R9: While `rst_ni` is low, `opnd_a_o` and `opnd_b_o` are 0.
- R10: The selects respond to input changes within the same clock phase, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the operand registers |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_a_id_i | input | ID_W | First source register id of the execute-stage instruction |
| src_b_id_i | input | ID_W | Second source register id of the execute-stage instruction |
| mem_we_i | input | 1 | Memory-stage instruction writes a register |
| mem_rd_i | input | ID_W | Memory-stage destination id |
| wb_we_i | input | 1 | Write-back-stage instruction writes a register |
| wb_rd_i | input | ID_W | Write-back-stage destination id |
| rf_a_data_i | input | DATA_W | Register-file value for operand A |
| rf_b_data_i | input | DATA_W | Register-file value for operand B |
| mem_data_i | input | DATA_W | Result held in the memory stage |
| wb_data_i | input | DATA_W | Result held in the write-back stage |
| fwd_a_o | output | 2 | Select code for operand A |
| fwd_b_o | output | 2 | Select code for operand B |
| opnd_a_o | output | DATA_W | Registered operand A |
| opnd_b_o | output | DATA_W | Registered operand B |

## Verification
The two functions that can fall in the same cycle are the memory-stage match and the write-back-stage match on the same source id. The bench provokes this by giving both stages the destination id that operand A reads, with different result values in each stage. It judges the outcome by requiring select 10 and then the memory-stage value at the operand register one edge later. Register-zero exclusion is tested against that same double match, and the two operands are driven to different stages in one cycle to show that they are decided independently.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int ID_W = 5
) (
  input  logic [ID_W-1:0] src_id_i,
  input  logic            mem_we_i,
  input  logic [ID_W-1:0] mem_rd_i,
  input  logic            wb_we_i,
  input  logic [ID_W-1:0] wb_rd_i,
  output fwd_pkg::fwd_sel_e sel_o
);
  logic mem_hit, wb_hit;

  always_comb begin
    mem_hit = mem_we_i && (mem_rd_i != '0) && (mem_rd_i == src_id_i);
    wb_hit  = wb_we_i  && (wb_rd_i  != '0) && (wb_rd_i  == src_id_i);
    // younger stage first
    if (mem_hit)     sel_o = fwd_pkg::FWD_MEM;
    else if (wb_hit) sel_o = fwd_pkg::FWD_WB;
    else             sel_o = fwd_pkg::FWD_RF;
  end
endmodule

// File: rtl/fwd_operand_mux.sv
module fwd_operand_mux #(
  parameter int DATA_W = 32
) (
  input  fwd_pkg::fwd_sel_e   sel_i,
  input  logic [DATA_W-1:0]   rf_i,
  input  logic [DATA_W-1:0]   wb_i,
  input  logic [DATA_W-1:0]   mem_i,
  output logic [DATA_W-1:0]   data_o
);
  always_comb begin
    unique case (sel_i)
      fwd_pkg::FWD_MEM: data_o = mem_i;
      fwd_pkg::FWD_WB:  data_o = wb_i;
      default:          data_o = rf_i;
    endcase
  end
endmodule

// File: rtl/fwd_opnd_reg.sv
module fwd_opnd_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= d_i;
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit #(
  parameter int ID_W   = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ID_W-1:0]   src_a_id_i,
  input  logic [ID_W-1:0]   src_b_id_i,
  input  logic              mem_we_i,
  input  logic [ID_W-1:0]   mem_rd_i,
  input  logic              wb_we_i,
  input  logic [ID_W-1:0]   wb_rd_i,
  input  logic [DATA_W-1:0] rf_a_data_i,
  input  logic [DATA_W-1:0] rf_b_data_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [DATA_W-1:0] wb_data_i,
  output logic [1:0]        fwd_a_o,
  output logic [1:0]        fwd_b_o,
  output logic [DATA_W-1:0] opnd_a_o,
  output logic [DATA_W-1:0] opnd_b_o
);
  localparam int NUM_SRC = 2;

  logic [ID_W-1:0]   src_id  [NUM_SRC];
  logic [DATA_W-1:0] rf_data [NUM_SRC];
  logic [DATA_W-1:0] mux_d   [NUM_SRC];
  logic [DATA_W-1:0] opnd_q  [NUM_SRC];
  fwd_pkg::fwd_sel_e sel     [NUM_SRC];

  assign src_id[0]  = src_a_id_i;
  assign src_id[1]  = src_b_id_i;
  assign rf_data[0] = rf_a_data_i;
  assign rf_data[1] = rf_b_data_i;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    fwd_match #(.ID_W(ID_W)) u_match (
      .src_id_i (src_id[g]),
      .mem_we_i (mem_we_i),
      .mem_rd_i (mem_rd_i),
      .wb_we_i  (wb_we_i),
      .wb_rd_i  (wb_rd_i),
      .sel_o    (sel[g])
    );

    fwd_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel_i  (sel[g]),
      .rf_i   (rf_data[g]),
      .wb_i   (wb_data_i),
      .mem_i  (mem_data_i),
      .data_o (mux_d[g])
    );

    fwd_opnd_reg #(.DATA_W(DATA_W)) u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (mux_d[g]),
      .q_o    (opnd_q[g])
    );
  end

  assign fwd_a_o  = sel[0];
  assign fwd_b_o  = sel[1];
  assign opnd_a_o = opnd_q[0];
  assign opnd_b_o = opnd_q[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int ID_W   = 5,
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ID_W-1:0]   src_a_id_i,
  input logic [ID_W-1:0]   src_b_id_i,
  input logic              mem_we_i,
  input logic [ID_W-1:0]   mem_rd_i,
  input logic              wb_we_i,
  input logic [ID_W-1:0]   wb_rd_i,
  input logic [DATA_W-1:0] rf_a_data_i,
  input logic [DATA_W-1:0] mem_data_i,
  input logic [DATA_W-1:0] wb_data_i,
  input logic [1:0]        fwd_a_o,
  input logic [1:0]        fwd_b_o,
  input logic [DATA_W-1:0] opnd_a_o,
  input logic [DATA_W-1:0] opnd_b_o
);
  AST_MEM_HIT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == src_a_id_i) |-> fwd_a_o == 2'b10); // R1
  AST_WB_HIT_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wb_we_i && wb_rd_i != '0 && wb_rd_i == src_a_id_i &&
     !(mem_we_i && mem_rd_i == src_a_id_i)) |-> fwd_a_o == 2'b01); // R2
  AST_NO_ILLEGAL_SEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_a_o != 2'b11 && fwd_b_o != 2'b11); // R3
  AST_MEM_HIT_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_i && mem_rd_i != '0 && mem_rd_i == src_b_id_i) |-> fwd_b_o == 2'b10); // R4
  AST_ZERO_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_a_id_i == '0) |-> fwd_a_o == 2'b00); // R5
  AST_WE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_we_i && !wb_we_i) |-> (fwd_a_o == 2'b00 && fwd_b_o == 2'b00)); // R7
  AST_OPND_A_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b00) |=> opnd_a_o == $past(rf_a_data_i)); // R8
  AST_OPND_A_MEM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b10) |=> opnd_a_o == $past(mem_data_i)); // R8
  AST_OPND_A_WB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_a_o == 2'b01) |=> opnd_a_o == $past(wb_data_i)); // R8
  AST_RST_CLEAR: assert property (@(posedge clk_i)
    !rst_ni |-> (opnd_a_o == '0 && opnd_b_o == '0)); // R9
endmodule

bind fwd_unit fwd_unit_chk #(.ID_W(ID_W), .DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .src_a_id_i  (src_a_id_i),
  .src_b_id_i  (src_b_id_i),
  .mem_we_i    (mem_we_i),
  .mem_rd_i    (mem_rd_i),
  .wb_we_i     (wb_we_i),
  .wb_rd_i     (wb_rd_i),
  .rf_a_data_i (rf_a_data_i),
  .mem_data_i  (mem_data_i),
  .wb_data_i   (wb_data_i),
  .fwd_a_o     (fwd_a_o),
  .fwd_b_o     (fwd_b_o),
  .opnd_a_o    (opnd_a_o),
  .opnd_b_o    (opnd_b_o)
);

// File: tb/fwd_unit_tb_top.sv
module fwd_unit_tb_top;
  localparam int ID_W   = 5;
  localparam int DATA_W = 32;
  localparam logic [DATA_W-1:0] RF_A = 32'hAAAA_0001;
  localparam logic [DATA_W-1:0] RF_B = 32'hBBBB_0002;
  localparam logic [DATA_W-1:0] MEMV = 32'hCCCC_0003;
  localparam logic [DATA_W-1:0] WBV  = 32'hDDDD_0004;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [ID_W-1:0]   src_a_id_i = '0, src_b_id_i = '0, mem_rd_i = '0, wb_rd_i = '0;
  logic              mem_we_i = 1'b0, wb_we_i = 1'b0;
  logic [DATA_W-1:0] rf_a_data_i = RF_A, rf_b_data_i = RF_B;
  logic [DATA_W-1:0] mem_data_i = MEMV, wb_data_i = WBV;
  logic [1:0]        fwd_a_o, fwd_b_o;
  logic [DATA_W-1:0] opnd_a_o, opnd_b_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  fwd_unit #(.ID_W(ID_W), .DATA_W(DATA_W)) dut_i (.*);

  task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] ref_sel(input logic [ID_W-1:0] s);
    if (mem_we_i && mem_rd_i != 0 && mem_rd_i == s) return 2'b10;
    if (wb_we_i && wb_rd_i != 0 && wb_rd_i == s)    return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic [DATA_W-1:0] ref_val(input logic [1:0] s, input logic [DATA_W-1:0] rf);
    return (s == 2'b10) ? MEMV : (s == 2'b01) ? WBV : rf;
  endfunction

  // drive just after an edge, check select, then check registered operand
  task automatic run(input string req, input logic [ID_W-1:0] sa, input logic [ID_W-1:0] sb,
                     input logic mwe, input logic [ID_W-1:0] mrd,
                     input logic wwe, input logic [ID_W-1:0] wrd,
                     input logic [1:0] exp_a, input logic [1:0] exp_b);
    @(posedge clk_i); #1;
    src_a_id_i = sa; src_b_id_i = sb;
    mem_we_i = mwe; mem_rd_i = mrd; wb_we_i = wwe; wb_rd_i = wrd;
    #0.5;
    chk({req, " sel_a"}, 32'(fwd_a_o), 32'(exp_a));
    chk({req, " sel_b"}, 32'(fwd_b_o), 32'(exp_b));
    @(posedge clk_i); #1;
    chk({req, " R8 opnd_a"}, opnd_a_o, ref_val(exp_a, RF_A));
    chk({req, " R8 opnd_b"}, opnd_b_o, ref_val(exp_b, RF_B));
  endtask

  task automatic t_reset;
    #5;
    chk("R9 opnd_a in reset", opnd_a_o, '0);
    chk("R9 opnd_b in reset", opnd_b_o, '0);
    src_a_id_i = 5'd3; mem_we_i = 1'b1; mem_rd_i = 5'd3;
    @(posedge clk_i); #1;
    chk("R9 opnd_a held in reset", opnd_a_o, '0);
    rst_ni = 1'b1;
  endtask

  task automatic t_mem_a;   run("R1", 5'd3, 5'd9, 1'b1, 5'd3, 1'b0, 5'd0, 2'b10, 2'b00); endtask
  task automatic t_wb_a;    run("R2", 5'd7, 5'd9, 1'b1, 5'd8, 1'b1, 5'd7, 2'b01, 2'b00); endtask
  task automatic t_none;    run("R3", 5'd4, 5'd5, 1'b1, 5'd6, 1'b1, 5'd12, 2'b00, 2'b00); endtask
  task automatic t_b_indep; run("R4", 5'd10, 5'd11, 1'b1, 5'd10, 1'b1, 5'd11, 2'b10, 2'b01);
                            run("R4 b only", 5'd1, 5'd31, 1'b1, 5'd31, 1'b0, 5'd0, 2'b00, 2'b10); endtask
  task automatic t_zero;    run("R5", 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, 2'b00, 2'b00); endtask
  task automatic t_prio;    run("R6", 5'd14, 5'd14, 1'b1, 5'd14, 1'b1, 5'd14, 2'b10, 2'b10); endtask
  task automatic t_we_low;  run("R7", 5'd2, 5'd2, 1'b0, 5'd2, 1'b0, 5'd2, 2'b00, 2'b00);
                            run("R7 mem off", 5'd2, 5'd6, 1'b0, 5'd2, 1'b1, 5'd2, 2'b01, 2'b00); endtask

  task automatic t_comb;
    @(posedge clk_i); #1;
    src_a_id_i = 5'd20; mem_we_i = 1'b1; mem_rd_i = 5'd20; wb_we_i = 1'b0;
    #0.5;
    chk("R10 sel_a first", 32'(fwd_a_o), 32'(2'b10));
    mem_we_i = 1'b0; wb_we_i = 1'b1; wb_rd_i = 5'd20;
    #0.5;
    chk("R10 sel_a same phase", 32'(fwd_a_o), 32'(2'b01));
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 32; s++) begin
      @(posedge clk_i); #1;
      src_a_id_i = ID_W'(s); src_b_id_i = ID_W'(31 - s);
      mem_we_i = 1'b1; mem_rd_i = ID_W'(s & 5'h1e);
      wb_we_i = 1'b1; wb_rd_i = ID_W'(s);
      #0.5;
      chk("R1 R2 R3 sweep a", 32'(fwd_a_o), 32'(ref_sel(src_a_id_i)));
      chk("R4 sweep b", 32'(fwd_b_o), 32'(ref_sel(src_b_id_i)));
    end
  endtask

  initial begin
    t_reset();
    t_mem_a();
    t_wb_a();
    t_none();
    t_b_indep();
    t_zero();
    t_prio();
    t_we_low();
    t_comb();
    t_sweep();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule